// File: doc/BRIEF.md
# Frame-Aligned Strobe Sequencer

This block lines up a set of internal control strobes with an external frame marker that arrives with no fixed relation to the local clock. The marker passes through a clock-domain synchroniser and a rising-edge detector. The result is a single-cycle restart pulse. A frame counter then walks through a writable lookup table, and every output bit of the table is a control strobe. One bit of the table is the internal frame marker. When that bit reads back as 1, the counter restarts by itself, so the pattern repeats on its own. An external marker restarts the counter too, at any point in the pattern, so the system can re-align whenever the master asks.

The block starts idle. While it is idle, software fills the table through a synchronous write port. The first external marker arms the sequencer, and from then on writes are refused. Only a reset returns the block to idle. The default table depth covers one full period of 516 transform lengths, and the transform length is a parameter.

Top module: `init_resync_seq`

## Requirements
- R1: After reset and until the first external marker is detected, `strobe_o` and `init_int_o` stay 0 and the counter stays at address 0, whatever the table holds.
- R2: Suppose `init_ext` rises before clock edge e0. Then `strobe_o` shows 0 after edge e2, and from edge e3 onward it shows entry A after edge e3+A. This gives two synchroniser stages plus one edge-detect stage, then one registered table read.
- R3: When `init_ext` stays high for several cycles, it produces exactly one restart.
- R4: When an entry with bit `INIT_BIT` set is shown on `strobe_o`, the next edge drives `strobe_o` to 0 and restarts at entry 0. If that bit is at entry A, the pattern repeats every A+2 cycles.
- R5: A detected external marker restarts the pattern in the middle of a sequence. The timing is the same as R2: 0, then entry 0, and so on.
- R6: When an external restart and an internal restart fall in the same cycle, they produce one restart. The pattern resumes exactly as after a single restart.
- R7: When no entry has bit `INIT_BIT` set, the counter wraps from DEPTH-1 to 0, and entry 0 follows entry DEPTH-1 directly.
- R8: A write (`lut_we`=1) changes the table only while the block is idle. Once the block is armed, writes are ignored, and later reads show the old contents.
- R9: `init_int_o` always equals bit `INIT_BIT` of `strobe_o`.
- R10: DEPTH is 516*FFT_LEN, and the address width is the ceiling of log2(DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the block to idle |
| init_ext | input | 1 | External frame marker, asynchronous, any pulse length |
| lut_we | input | 1 | Table write enable (accepted only when idle) |
| lut_addr | input | AW | Table write address |
| lut_wdata | input | DW | Table write data |
| strobe_o | output | DW | Registered table output, the control strobes |
| init_int_o | output | 1 | Internal frame marker, bit INIT_BIT of the strobes |

## Verification
A wrong counter or a lost restart shifts the whole strobe pattern. This shows on `strobe_o` at the first nonzero table entry that falls in a different cycle, which is at most one pattern period later. A stuck armed state shows at once: either strobes appear before any marker, or a refused write shows up on a later read. A double restart or a missed edge detection changes the gap between two consecutive entry-0 reads, so a bench that follows every cycle sees it within a few clocks of the marker.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int FRAME_FFT_CYCLES = 516;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } seq_phase_e;
endpackage

// File: rtl/init_edge_sync.sv
module init_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic pulse_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("init_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];

   assign pulse_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/seq_count.sv
module seq_count #(
   parameter int DEPTH = 1032,
   parameter int AW    = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          restart_i,
   output logic [AW-1:0] cnt_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 cnt_o <= '0;
      else if (!run_i || restart_i) cnt_o <= '0;
      else if (cnt_o == LAST)     cnt_o <= '0;
      else                        cnt_o <= cnt_o + 1'b1;
endmodule

// File: rtl/seq_lut.sv
module seq_lut #(
   parameter int DEPTH = 1032,
   parameter int AW    = 11,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          clr_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] q_o
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk)
      if (we_i) mem[waddr_i] <= wdata_i;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     q_o <= '0;
      else if (clr_i) q_o <= '0;
      else            q_o <= mem[raddr_i];
endmodule

// File: rtl/init_resync_seq.sv
module init_resync_seq
   import seq_pkg::*;
#(
   parameter int FFT_LEN     = 2,
   parameter int DW          = 8,
   parameter int INIT_BIT    = 0,
   parameter int SYNC_STAGES = 2,
   localparam int DEPTH      = FRAME_FFT_CYCLES * FFT_LEN,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_ext,
   input  logic          lut_we,
   input  logic [AW-1:0] lut_addr,
   input  logic [DW-1:0] lut_wdata,
   output logic [DW-1:0] strobe_o,
   output logic          init_int_o
);
   generate
      if (INIT_BIT < 0 || INIT_BIT >= DW) begin : g_bad_bit
         $error("init_resync_seq: INIT_BIT outside strobe width");
      end
      if (FFT_LEN < 1) begin : g_bad_len
         $error("init_resync_seq: FFT_LEN must be positive");
      end
   endgenerate

   seq_phase_e    phase_q;
   logic          ext_pulse;
   logic          restart;
   logic          armed;
   logic [AW-1:0] cnt;
   logic [DW-1:0] lut_q;

   init_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (init_ext),
      .pulse_o (ext_pulse)
   );

   assign armed   = (phase_q == PH_RUN);
   assign restart = ext_pulse | (armed & lut_q[INIT_BIT]);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         phase_q <= PH_IDLE;
      else if (ext_pulse) phase_q <= PH_RUN;

   seq_count #(.DEPTH(DEPTH), .AW(AW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (armed),
      .restart_i (restart),
      .cnt_o     (cnt)
   );

   seq_lut #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (lut_we & ~armed),
      .waddr_i (lut_addr),
      .wdata_i (lut_wdata),
      .clr_i   (~armed | restart),
      .raddr_i (cnt),
      .q_o     (lut_q)
   );

   assign strobe_o   = lut_q;
   assign init_int_o = lut_q[INIT_BIT];
endmodule

// File: rtl/init_resync_seq_chk.sv
module init_resync_seq_chk #(
   parameter int DEPTH = 1032,
   parameter int AW    = 11,
   parameter int DW    = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          armed,
   input logic          ext_pulse,
   input logic          restart,
   input logic [AW-1:0] cnt,
   input logic [DW-1:0] strobe_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   // R1: idle keeps the strobes quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> strobe_o == '0);

   // R3: the edge detector never emits two pulses in a row
   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_pulse |=> !ext_pulse);

   // R4, R5, R6: a restart returns the counter to 0 and clears the output
   p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0 && strobe_o == '0));

   // R7: the counter steps by one while running
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !restart && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);

   // R8: once armed, the block stays armed
   p_stay_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);
endmodule

bind init_resync_seq init_resync_seq_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .armed     (armed),
   .ext_pulse (ext_pulse),
   .restart   (restart),
   .cnt       (cnt),
   .strobe_o  (strobe_o)
);

// File: tb/init_resync_seq_tb_top.sv
module init_resync_seq_tb_top;
   localparam int FFT_LEN  = 2;
   localparam int DW       = 8;
   localparam int INIT_BIT = 0;
   localparam int DEPTH    = 516 * FFT_LEN;
   localparam int AW       = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init_ext = 1'b0;
   logic          lut_we = 1'b0;
   logic [AW-1:0] lut_addr = '0;
   logic [DW-1:0] lut_wdata = '0;
   logic [DW-1:0] strobe_o;
   logic          init_int_o;

   int    n_checks = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   init_resync_seq #(.FFT_LEN(FFT_LEN), .DW(DW), .INIT_BIT(INIT_BIT)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_ext   (init_ext),
      .lut_we     (lut_we),
      .lut_addr   (lut_addr),
      .lut_wdata  (lut_wdata),
      .strobe_o   (strobe_o),
      .init_int_o (init_int_o)
   );

   // behavioural reference
   logic [DW-1:0] m_mem [DEPTH];
   bit            m_s1, m_s2, m_s3, m_armed;
   logic [DW-1:0] m_q;
   int            m_pos;

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_armed = 0; m_q = '0; m_pos = 0;
      end else begin
         bit pulse, rs;
         pulse = m_s2 && !m_s3;
         rs    = pulse || (m_armed && m_q[INIT_BIT]);
         if (!m_armed && lut_we) m_mem[lut_addr] = lut_wdata;
         if (!m_armed) begin
            m_q = '0;
            if (pulse) begin m_armed = 1; m_pos = 0; end
         end else if (rs) begin
            m_q = '0; m_pos = 0;
         end else begin
            m_q = m_mem[m_pos];
            m_pos = (m_pos + 1) % DEPTH;
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = init_ext;
      end
   end

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         check(cur_req, strobe_o, m_q);
         check("R9", DW'(init_int_o), DW'(m_q[INIT_BIT]));
      end
      if (cyc > 150000) begin
         n_checks++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      lut_we = 1'b1; lut_addr = AW'(a); lut_wdata = DW'(d);
      @(negedge clk);
      lut_we = 1'b0;
   endtask

   task automatic pulse_ext(int len);
      @(negedge clk);
      init_ext = 1'b1;
      wait_cyc(len);
      init_ext = 1'b0;
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      cur_req = "R1";
      check("R1", strobe_o, '0);
      // fill the table while idle
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) begin
         lut_we = 1'b1; lut_addr = AW'(i); lut_wdata = '0;
         @(negedge clk);
      end
      lut_we = 1'b0;
      wr(0, 8'h02);
      wr(1, 8'h04);
      wr(3, 8'h80);
      wr(5, 8'h11);    // INIT_BIT set: period 7
      wait_cyc(20);    // idle, table nonzero
      // first marker, held several cycles
      cur_req = "R2";
      pulse_ext(4);
      cur_req = "R3";
      wait_cyc(12);
      cur_req = "R4";
      wait_cyc(40);
      // marker in the middle of a pattern
      cur_req = "R5";
      wait_cyc(2);
      pulse_ext(1);
      wait_cyc(15);
      // sweep marker offsets to hit a cycle shared with the internal restart
      cur_req = "R6";
      for (int off = 0; off < 8; off++) begin
         wait_cyc(off);
         pulse_ext(2);
         wait_cyc(12);
      end
      // writes refused while armed
      cur_req = "R8";
      wr(1, 8'hFF);
      wr(3, 8'h00);
      wait_cyc(30);
      // back to idle, remove the internal marker, check the wrap
      rst_n = 1'b0;
      wait_cyc(2);
      rst_n = 1'b1;
      cur_req = "R1";
      check("R1", strobe_o, '0);
      wr(5, 8'h10);
      wr(DEPTH - 1, 8'h40);
      cur_req = "R7";
      pulse_ext(1);
      wait_cyc(2 * DEPTH + 30);
      cur_req = "R10";
      wait_cyc(5);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule